// File: doc/BRIEF.md
# Query and identifier response formatter

This block forms the read data returned while a parallel flash bank is in query mode or in identifier mode. The bank is built from several identical narrow devices wired side by side. Each device may also run narrower than its native width. The block turns a bus address into a per-device table index, then looks up either a byte of a fixed query table or a manufacturer/device code. It replicates that per-device answer across every device lane of the bank, so software sees what a bank of real devices would return together.

A read wider than the bank is assembled from several bank-wide lookups, one per bank-sized slot of the data word. The result is registered on the read strobe and appears one cycle later with a valid flag. The bus controller that owns the command state machine drives the mode bit and the three width fields. It consumes the registered word.

Top module: `qid_resp_fmt`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rd_valid` and `rd_data` become zero.
- R2: `rd_valid` is high exactly in the cycle after a cycle with `rd_stb` high. `rd_data` takes the formatted word at that edge and holds its value whenever `rd_stb` is low.
- R3: Width fields are log2 byte counts (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). The table index is the slot address shifted right by `bank_lg + max_lg - dev_lg`.
- R4: The query table has 82 entries (indices 0x00..0x51). Index 0x10/0x11/0x12 hold 0x51/0x52/0x59, 0x13 holds 0x01, 0x15 holds 0x31, 0x2C holds 0x01, and 0x31/0x32/0x33 hold 0x50/0x52/0x49. Index 0x34 holds 0x31 and 0x35 holds 0x30. Every other entry is 0x00.
- R5: In query mode, an index of 0x52 or more gives a zero byte.
- R6: In query mode with device width equal to its maximum width, the device answer carries the table byte in its lowest byte and zeros in its other bytes.
- R7: In query mode with device width below the maximum width, a 1-byte device repeats the table byte in every byte it drives, and any wider device answers zero.
- R8: The device answer is copied into every device-width slice of the bank; byte j of the bank equals byte (j mod device width) of the device answer.
- R9: In identifier mode (`id_mode` = 1), the low 8 index bits select the answer: 0 gives MFR_CODE, 1 gives DEV_CODE and any other value gives zero. The 16-bit code is cut to the low byte for a 1-byte device and zero-extended for a 4-byte device.
- R10: Data byte j belongs to slot k = j / bank width. Slot k is looked up at address `rd_addr + k * bank * bank`, modulo 2^ADDR_W, and fills its bytes from the bank word starting at byte offset k * bank.
- R11: `rd_size` is the log2 read width (0 = 1, 1 = 2, 2 = 4 bytes, 3 = the whole word). Data bytes at or above the read width are zero.
- R12: A width field of 3, a device wider than its maximum width, or a device wider than the bank makes the whole word zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_size | input | 2 | log2 of the read width in bytes |
| id_mode | input | 1 | 1 = identifier mode, 0 = query mode |
| bank_lg | input | 2 | log2 of the bank width in bytes |
| dev_lg | input | 2 | log2 of the device width in use |
| max_lg | input | 2 | log2 of the device's native maximum width |
| rd_data | output | DATA_W | Registered formatted response |
| rd_valid | output | 1 | High one cycle after each strobe |

## Verification
Every response is due exactly one clock edge after the edge that samples its strobe. There is no other latency path, so back-to-back strobes yield back-to-back results in order. The bench drives each strobe on a falling edge and queues the expected word at the same time. A monitor compares `rd_valid` and `rd_data` on the following falling edge, so each expected word meets the edge that registered it. The hold behaviour is checked over several idle cycles after a result, before any further strobe.

// File: rtl/qry_pkg.sv
// Package: shared constants and the fixed query table contents.
// Assumes table indices below QRY_TBL_DEPTH fit in 7 bits.
package qry_pkg;

    localparam int          QRY_TBL_DEPTH = 82;
    localparam logic [1:0]  LG_RESERVED   = 2'd3;

    // Fixed query table byte for an in-range index
    function automatic logic [7:0] qry_rom_byte(input logic [6:0] idx);
        case (idx)
            7'h10:   return 8'h51;
            7'h11:   return 8'h52;
            7'h12:   return 8'h59;
            7'h13:   return 8'h01;
            7'h15:   return 8'h31;
            7'h2C:   return 8'h01;
            7'h31:   return 8'h50;
            7'h32:   return 8'h52;
            7'h33:   return 8'h49;
            7'h34:   return 8'h31;
            7'h35:   return 8'h30;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/qry_index_calc.sv
// Module: turns the bus address into the per-device table index of one slot.
// Assumes a valid width configuration; bad ones are zeroed by the top.
module qry_index_calc #(
    parameter int ADDR_W = 12,
    parameter int SLOT   = 0
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [1:0]        bank_lg,
    input  logic [1:0]        dev_lg,
    input  logic [1:0]        max_lg,
    output logic [ADDR_W-1:0] idx
);

    logic [ADDR_W-1:0] slot_addr;
    logic [2:0]        shamt;

    // Offset the address by slot * bank * bank and normalise to the native width
    always_comb begin
        slot_addr = base_addr + (ADDR_W'(SLOT) << {bank_lg, 1'b0});
        shamt     = {1'b0, bank_lg} + {1'b0, max_lg} - {1'b0, dev_lg};
        idx       = slot_addr >> shamt;
    end

endmodule

// File: rtl/qry_dev_answer.sv
// Module: forms the answer of a single device for one table index.
// Bytes above the device width are zero. Assumes ADDR_W >= 8, DATA_W >= 16.
module qry_dev_answer
    import qry_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32,
    parameter logic [15:0] MFR_CODE = 16'h0049,
    parameter logic [15:0] DEV_CODE = 16'h8817
) (
    input  logic [ADDR_W-1:0] idx,
    input  logic              id_mode,
    input  logic [1:0]        dev_lg,
    input  logic [1:0]        max_lg,
    output logic [DATA_W-1:0] dev_word
);

    logic        in_table;
    logic [7:0]  tbl_byte;
    logic [15:0] code;

    // Query table lookup with out-of-range indices reading zero
    always_comb begin
        in_table = (idx < ADDR_W'(QRY_TBL_DEPTH));
        tbl_byte = in_table ? qry_rom_byte(idx[6:0]) : 8'h00;
    end

    // Identifier selection from the low eight index bits
    always_comb begin
        case (idx[7:0])
            8'd0:    code = MFR_CODE;
            8'd1:    code = DEV_CODE;
            default: code = 16'h0000;
        endcase
    end

    // Fit the chosen value to the device width
    always_comb begin
        dev_word = '0;
        if (id_mode) begin
            if (dev_lg == 2'd0) dev_word[7:0]  = code[7:0];
            else                dev_word[15:0] = code;
        end else if ((dev_lg == max_lg) || (dev_lg == 2'd0)) begin
            dev_word[7:0] = tbl_byte;
        end
    end

endmodule

// File: rtl/qry_bank_replicate.sv
// Module: copies a device answer into every device lane of the bank.
// Assumes bank width and device width are at most DATA_W/8 bytes.
module qry_bank_replicate #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] dev_word,
    input  logic [1:0]        dev_lg,
    input  logic [1:0]        bank_lg,
    output logic [DATA_W-1:0] bank_word
);

    localparam int NBYTES = DATA_W / 8;

    // Byte j of the bank takes byte (j mod device width) of the device answer
    always_comb begin
        bank_word = '0;
        for (int j = 0; j < NBYTES; j++) begin
            if (j < (32'sd1 <<< bank_lg)) begin
                bank_word[8*j +: 8] = dev_word[8*(j & ((32'sd1 <<< dev_lg) - 1)) +: 8];
            end
        end
    end

endmodule

// File: rtl/qid_resp_fmt.sv
// Module: top of the query/identifier response formatter.
// One lookup per bank-sized slot, slot assembly, size masking and an output
// register loaded on the read strobe. Assumes DATA_W >= 32 and ADDR_W >= 8.
module qid_resp_fmt
    import qry_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32,
    parameter logic [15:0] MFR_CODE = 16'h0049,
    parameter logic [15:0] DEV_CODE = 16'h8817
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        rd_size,
    input  logic              id_mode,
    input  logic [1:0]        bank_lg,
    input  logic [1:0]        dev_lg,
    input  logic [1:0]        max_lg,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] slot_word [NBYTES];
    logic [DATA_W-1:0] fmt_word;
    logic              cfg_ok;

    for (genvar k = 0; k < NBYTES; k++) begin : g_slot
        logic [ADDR_W-1:0] idx;
        logic [DATA_W-1:0] dev_word;

        qry_index_calc #(.ADDR_W(ADDR_W), .SLOT(k)) u_idx (
            .base_addr (rd_addr),
            .bank_lg   (bank_lg),
            .dev_lg    (dev_lg),
            .max_lg    (max_lg),
            .idx       (idx)
        );

        qry_dev_answer #(
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .MFR_CODE (MFR_CODE),
            .DEV_CODE (DEV_CODE)
        ) u_ans (
            .idx      (idx),
            .id_mode  (id_mode),
            .dev_lg   (dev_lg),
            .max_lg   (max_lg),
            .dev_word (dev_word)
        );

        qry_bank_replicate #(.DATA_W(DATA_W)) u_rep (
            .dev_word  (dev_word),
            .dev_lg    (dev_lg),
            .bank_lg   (bank_lg),
            .bank_word (slot_word[k])
        );
    end

    // Reject reserved or inconsistent width settings
    always_comb begin
        cfg_ok = (bank_lg != LG_RESERVED) && (dev_lg != LG_RESERVED) &&
                 (max_lg != LG_RESERVED) && (dev_lg <= max_lg) &&
                 (dev_lg <= bank_lg);
    end

    // Place each slot at byte offset slot * bank and mask to the read width
    always_comb begin
        fmt_word = '0;
        for (int j = 0; j < NBYTES; j++) begin
            if (cfg_ok && (j < (32'sd1 <<< rd_size))) begin
                fmt_word[8*j +: 8] =
                    slot_word[j >> bank_lg][8*(j & ((32'sd1 <<< bank_lg) - 1)) +: 8];
            end
        end
    end

    // Output register loaded on the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) rd_data <= fmt_word;
        end
    end

endmodule

// File: rtl/qid_resp_fmt_chk.sv
// Module: property checker for qid_resp_fmt, attached by bind below.
module qid_resp_fmt_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input logic [1:0]        rd_size,
    input logic [1:0]        bank_lg,
    input logic [1:0]        dev_lg,
    input logic [1:0]        max_lg,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid
);

    AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_valid); // R2
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data)); // R2
    AST_ONE_BYTE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_size == 2'd0) |=> (rd_data[DATA_W-1:8] == '0)); // R11
    AST_BAD_CFG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && dev_lg > max_lg) |=> (rd_data == '0)); // R12
    AST_LANES_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && dev_lg == 2'd0 && bank_lg == 2'd1 && max_lg != 2'd3 && rd_size == 2'd1)
        |=> (rd_data[15:8] == rd_data[7:0])); // R8

endmodule

bind qid_resp_fmt qid_resp_fmt_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb   (rd_stb),
    .rd_size  (rd_size),
    .bank_lg  (bank_lg),
    .dev_lg   (dev_lg),
    .max_lg   (max_lg),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
);

// File: tb/qid_resp_fmt_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard for qid_resp_fmt. The driver queues the expected word of
// each strobe; the monitor compares on the falling edge after the result edge.
module qid_resp_fmt_tb_top;

    localparam logic [15:0] MFR = 16'h0049;
    localparam logic [15:0] DEV = 16'h8817;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [1:0]  rd_size = '0;
    logic        id_mode = 1'b0;
    logic [1:0]  bank_lg = '0;
    logic [1:0]  dev_lg = '0;
    logic [1:0]  max_lg = '0;
    logic [31:0] rd_data;
    logic        rd_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    qid_resp_fmt #(.ADDR_W(12), .DATA_W(32), .MFR_CODE(MFR), .DEV_CODE(DEV)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .rd_size(rd_size), .id_mode(id_mode), .bank_lg(bank_lg),
        .dev_lg(dev_lg), .max_lg(max_lg), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic [7:0] tbl_ref(input int i);
        case (i)
            16: return 8'h51; 17: return 8'h52; 18: return 8'h59; 19: return 8'h01;
            21: return 8'h31; 44: return 8'h01; 49: return 8'h50; 50: return 8'h52;
            51: return 8'h49; 52: return 8'h31; 53: return 8'h30;
            default: return 8'h00;
        endcase
    endfunction

    // Expected word derived from the requirements
    function automatic logic [31:0] model(input logic [11:0] addr, input logic [1:0] sz,
                                          input logic idm, input logic [1:0] lb,
                                          input logic [1:0] ld, input logic [1:0] lm);
        int bank, dev, nb, k, off, pos, sh;
        logic [11:0] a, idx;
        logic [7:0]  v;
        logic [15:0] code;
        logic [31:0] r;
        r = '0;
        if (lb == 3 || ld == 3 || lm == 3 || ld > lm || ld > lb) return '0;
        bank = 1 << lb; dev = 1 << ld; sh = lb + lm - ld;
        nb = (sz == 3) ? 4 : (1 << sz);
        for (int j = 0; j < 4; j++) begin
            if (j < nb) begin
                k = j / bank; off = j % bank; pos = off % dev;
                a = addr + 12'(k * bank * bank);
                idx = a >> sh;
                if (idm) begin
                    code = (idx[7:0] == 0) ? MFR : (idx[7:0] == 1) ? DEV : 16'h0;
                    v = (pos == 0) ? code[7:0] : (pos == 1) ? code[15:8] : 8'h00;
                end else if (ld < lm && ld != 0) v = 8'h00;
                else if (idx >= 82) v = 8'h00;
                else v = (pos == 0) ? tbl_ref(int'(idx)) : 8'h00;
                r[8*j +: 8] = v;
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Driver: one strobe per call, expected word pushed to the scoreboard
    task automatic issue(input logic [11:0] a, input logic [1:0] sz, input logic idm,
                         input logic [1:0] lb, input logic [1:0] ld, input logic [1:0] lm,
                         input string tag);
        @(negedge clk);
        rd_addr = a; rd_size = sz; id_mode = idm;
        bank_lg = lb; dev_lg = ld; max_lg = lm; rd_stb = 1'b1;
        exp_q.push_back(model(a, sz, idm, lb, ld, lm));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_stb = 1'b0;
        end
    endtask

    // Monitor: compare each valid result with the oldest queued item
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) check("R2 unexpected valid", 32'h1, 32'h0);
            else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {31'b0, rd_valid}, 32'h0);
        check("R1 reset data", rd_data, 32'h0);
        rst_n = 1'b1;

        issue(12'h010, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0, "R4 Q byte");
        issue(12'h011, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0, "R4 R byte");
        issue(12'h012, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0, "R4 Y byte");
        issue(12'h033, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0, "R4 I byte");
        issue(12'h020, 2'd1, 1'b0, 2'd1, 2'd1, 2'd1, "R3 R6 x16 shift");
        issue(12'h044, 2'd2, 1'b0, 2'd2, 2'd0, 2'd0, "R8 four byte lanes");
        issue(12'h0C4, 2'd2, 1'b0, 2'd2, 2'd1, 2'd1, "R8 two x16 lanes");
        issue(12'h048, 2'd1, 1'b0, 2'd1, 2'd0, 2'd1, "R7 byte mode repeat");
        issue(12'h080, 2'd2, 1'b0, 2'd2, 2'd1, 2'd2, "R7 unsupported narrow");
        issue(12'h052, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0, "R5 index 0x52");
        issue(12'h152, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0, "R5 index 0x152");
        idle(2);
        issue(12'h000, 2'd1, 1'b1, 2'd1, 2'd1, 2'd1, "R9 manufacturer");
        issue(12'h002, 2'd1, 1'b1, 2'd1, 2'd1, 2'd1, "R9 device code");
        issue(12'h001, 2'd0, 1'b1, 2'd0, 2'd0, 2'd0, "R9 byte truncation");
        issue(12'h004, 2'd2, 1'b1, 2'd2, 2'd2, 2'd2, "R9 zero extend");
        issue(12'h100, 2'd0, 1'b1, 2'd0, 2'd0, 2'd0, "R9 low index bits");
        issue(12'h002, 2'd0, 1'b1, 2'd0, 2'd0, 2'd0, "R9 other index");
        issue(12'h010, 2'd2, 1'b0, 2'd0, 2'd0, 2'd0, "R10 four slots");
        issue(12'h020, 2'd2, 1'b0, 2'd1, 2'd1, 2'd1, "R10 two slots");
        issue(12'hFFF, 2'd2, 1'b1, 2'd0, 2'd0, 2'd0, "R10 address wrap");
        issue(12'h044, 2'd0, 1'b0, 2'd2, 2'd0, 2'd0, "R11 one byte");
        issue(12'h044, 2'd1, 1'b0, 2'd2, 2'd0, 2'd0, "R11 two bytes");
        issue(12'h044, 2'd3, 1'b0, 2'd2, 2'd0, 2'd0, "R11 whole word");
        issue(12'h020, 2'd2, 1'b0, 2'd0, 2'd1, 2'd1, "R12 device over bank");
        issue(12'h040, 2'd2, 1'b0, 2'd2, 2'd2, 2'd1, "R12 device over max");
        issue(12'h010, 2'd2, 1'b0, 2'd3, 2'd0, 2'd0, "R12 reserved field");
        idle(2);

        issue(12'h044, 2'd2, 1'b0, 2'd2, 2'd0, 2'd0, "R2 hold source");
        idle(1);
        held = rd_data;
        rd_addr = 12'h010; id_mode = 1'b1;
        idle(3);
        check("R2 hold data", rd_data, held);
        check("R2 hold valid", {31'b0, rd_valid}, 32'h0);
        check("R2 hold value", held, 32'h52525252);

        idle(4);
        check("R2 queue drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule